// File: doc/BRIEF.md
# Strap-Selected General-Purpose I/O Port

This block turns eight pins of an unused parallel host port into a general-purpose I/O port. A CPU controls it through a small word-wide register bus. One register sets the direction of each pin. A second register holds the values to drive, and when read it gives the live pin levels. Output pins return the value that was written. Input pins return their pad level after it passes through a two-flop synchroniser.

A strap input is sampled on every clock while reset is held, and its value at the release of reset is kept. A low strap enables the I/O function. A high strap leaves the pins to the host port. In that case the block never enables a pad driver and ignores all register writes. Registers can still be read in either mode.

Top module: `strap_gpio_port`

## Requirements
- R1: `hostEnStrap` is captured on each clock edge while `rstN` is low. Low selects I/O mode and high selects host mode. The captured mode holds after reset is released, whatever the strap does later.
- R2: After reset, the direction and output-value registers are 0. `padOe` is 0, and reads of both registers return 0 except for the synchronised pad bits in the status word.
- R3: A write to address 16'h003C loads bits [7:0] into the direction register. In I/O mode, bit n = 1 sets `padOe[n]` to 1 (pin n is an output) and bit n = 0 makes pin n an input. The change shows from the first clock edge after the write.
- R4: A write to address 16'h003D loads bits [7:0] into the output-value register, and `padOut` shows that value. Writing 16'h00FF to 003C and then 16'h0040 to 003D gives `padOe`=8'hFF and `padOut`=8'b01000000.
- R5: A read of 003C returns {8'h00, direction}.
- R6: A read of 003D returns a word whose upper 8 bits are zero. In the low byte, bit n is the stored output value when pin n is an output, and the synchronised pad level when pin n is an input.
- R7: A change on `padIn` is not visible in a read after one clock edge. It is visible after the second clock edge.
- R8: In host mode, `padOe` and `padOut` stay 0, and writes to both registers are ignored. Read-back shows direction 0.
- R9: Writes to any other address change nothing. A read of any other address, or with `regRdEn` low, returns 0.
- R10: Bits [15:8] of a write to either register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; the strap is sampled while it is low |
| hostEnStrap | input | 1 | Mode strap: 0 selects I/O mode, 1 selects host mode |
| regAddr | input | 16 | Register word address |
| regWrData | input | 16 | Write data |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regRdEn | input | 1 | Read strobe; read data is combinational |
| regRdData | output | 16 | Read data, 0 when no register is selected |
| padIn | input | 8 | Pad input levels, asynchronous |
| padOut | output | 8 | Values driven on the pads |
| padOe | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The embedded assertions check, on every cycle:
- the captured mode never changes outside reset;
- the direction register stays 0 in host mode;
- each register holds its value unless it is written;
- a write lands on the next clock edge.

Some behaviour only the bench's scenarios can show. These are the two-edge latency of the synchroniser, the per-bit mix of stored values and pad levels in the status read, the zero result for unmapped addresses, and the strap changing after reset. The bench runs random register traffic and pad changes against a reference model in I/O mode. It also runs directed checks in host mode.

// File: rtl/strap_gpio_pkg.sv
package strap_gpio_pkg;
  localparam int PORT_W = 8;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic wrDir;
    logic wrVal;
    logic rdDir;
    logic rdVal;
  } regStrobe_t;
endpackage

// File: rtl/strap_gpio_ctrl.sv
module strap_gpio_ctrl
  import strap_gpio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'h003C,
  parameter logic [ADDR_W-1:0] VAL_ADDR = 16'h003D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEnStrap,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output logic              gpioMode,
  output regStrobe_t        strobe
);
  logic modeQ;
  logic hitDir;
  logic hitVal;

  // Strap is sampled every cycle during reset; value at release is kept
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= ~hostEnStrap;
  end

  assign gpioMode = modeQ;
  assign hitDir   = (regAddr == DIR_ADDR);
  assign hitVal   = (regAddr == VAL_ADDR);

  always_comb begin
    strobe.wrDir = regWrEn && hitDir && modeQ;
    strobe.wrVal = regWrEn && hitVal && modeQ;
    strobe.rdDir = regRdEn && hitDir;
    strobe.rdVal = regRdEn && hitVal;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeQ)) else $error("mode changed after reset"); // R1
endmodule

// File: rtl/strap_gpio_datapath.sv
module strap_gpio_datapath
  import strap_gpio_pkg::*;
#(
  parameter int PW = PORT_W,
  parameter int DW = WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          gpioMode,
  input  regStrobe_t    strobe,
  input  logic [PW-1:0] wrByte,
  input  logic [PW-1:0] padIn,
  output logic [DW-1:0] rdData,
  output logic [PW-1:0] padOut,
  output logic [PW-1:0] padOe
);
  localparam int PAD_W = DW - PW;

  logic [PW-1:0] dirQ;
  logic [PW-1:0] valQ;
  logic [PW-1:0] syncQ [SYNC_STAGES];
  logic [PW-1:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '0;
      valQ <= '0;
    end else begin
      if (strobe.wrDir) dirQ <= wrByte;
      if (strobe.wrVal) valQ <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar b = 0; b < PW; b++) begin : gBit
    assign statusByte[b] = dirQ[b] ? valQ[b] : syncQ[SYNC_STAGES-1][b];
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdDir)      rdData = {{PAD_W{1'b0}}, dirQ};
    else if (strobe.rdVal) rdData = {{PAD_W{1'b0}}, statusByte};
  end

  assign padOe  = gpioMode ? dirQ : '0;
  assign padOut = gpioMode ? valQ : '0;

  AST_HOST_DIR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !gpioMode |-> dirQ == '0) else $error("direction set in host mode"); // R8
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> dirQ == $past(wrByte)) else $error("dir write lost"); // R3
  AST_VAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrVal |=> valQ == $past(wrByte)) else $error("value write lost"); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirQ)) else $error("dir changed unwritten"); // R9
  AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrVal |=> $stable(valQ)) else $error("value changed unwritten"); // R9
endmodule

// File: rtl/strap_gpio_port.sv
module strap_gpio_port
  import strap_gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEnStrap,
  input  logic [WORD_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output logic [WORD_W-1:0] regRdData,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe
);
  logic       gpioMode;
  regStrobe_t strobe;

  strap_gpio_ctrl #(.ADDR_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hostEnStrap(hostEnStrap), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .gpioMode(gpioMode), .strobe(strobe)
  );

  strap_gpio_datapath #(.PW(PORT_W), .DW(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .gpioMode(gpioMode), .strobe(strobe),
    .wrByte(regWrData[PORT_W-1:0]), .padIn(padIn), .rdData(regRdData),
    .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/tb_strap_gpio_port.sv
module tb_strap_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_DIR = 16'h003C;
  localparam logic [15:0] A_VAL = 16'h003D;

  logic clk = 0;
  logic rstN = 0;
  logic hostEnStrap = 0;
  logic [15:0] regAddr = '0, regWrData = '0, regRdData;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] padIn = '0, padOut, padOe;

  int errors = 0;
  int checks = 0;
  logic [7:0] expDir, expVal;
  logic expGpio;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_gpio_port dut (
    .clk(clk), .rstN(rstN), .hostEnStrap(hostEnStrap), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regRdData(regRdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [15:0] expStatus(logic [7:0] d, logic [7:0] v, logic [7:0] p);
    return {8'h00, (d & v) | (~d & p)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 0; hostEnStrap = strap;
    repeat (3) @(negedge clk);
    rstN = 1;
    expDir = '0; expVal = '0; expGpio = ~strap;
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
    if (expGpio && a == A_DIR) expDir = d[7:0];
    if (expGpio && a == A_VAL) expVal = d[7:0];
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [15:0] exp, input string tag);
    regAddr = a; regRdEn = 1;
    #1 chk(tag, regRdData, exp);
    regRdEn = 0;
  endtask

  task automatic padChk(input string tag);
    chk({tag, " oe"},  {8'h00, padOe},  expGpio ? {8'h00, expDir} : 16'h0);
    chk({tag, " out"}, {8'h00, padOut}, expGpio ? {8'h00, expVal} : 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    // Host mode
    doReset(1'b1);
    @(negedge clk); hostEnStrap = 0;        // R1 strap change after reset ignored
    padIn = 8'h5A;
    wrReg(A_DIR, 16'h00FF);
    wrReg(A_VAL, 16'h00AA);
    repeat (2) @(negedge clk);
    chk("R1 mode held, R8 oe", {8'h00, padOe}, 16'h0);
    chk("R8 out", {8'h00, padOut}, 16'h0);
    rdChk(A_DIR, 16'h0000, "R8 dir write ignored");
    rdChk(A_VAL, 16'h005A, "R8 value write ignored");

    // I/O mode
    padIn = 8'h00;
    doReset(1'b0);
    chk("R2 oe after reset", {8'h00, padOe}, 16'h0);
    rdChk(A_DIR, 16'h0000, "R2 dir reset");
    rdChk(A_VAL, 16'h0000, "R2 value reset");
    wrReg(A_DIR, 16'h00FF);
    padChk("R3 all outputs");
    wrReg(A_VAL, 16'h0040);
    chk("R4 pattern", {padOe, padOut}, 16'hFF40);
    rdChk(A_VAL, 16'h0040, "R6 readback outputs");
    wrReg(A_DIR, 16'hFF0F);
    rdChk(A_DIR, 16'h000F, "R10 upper dir bits, R5 read");
    wrReg(A_VAL, 16'hA5C3);
    rdChk(A_VAL, expStatus(8'h0F, 8'hC3, 8'h00), "R10 upper value bits");
    wrReg(16'h003E, 16'h00FF);
    wrReg(16'h013C, 16'h0000);
    rdChk(A_DIR, 16'h000F, "R9 other address write");
    rdChk(16'h003E, 16'h0000, "R9 other address read");
    regAddr = A_DIR; #1 chk("R9 no read strobe", regRdData, 16'h0);

    // Synchroniser latency
    wrReg(A_DIR, 16'h0000);
    @(negedge clk); padIn = 8'hFF;
    @(negedge clk);
    rdChk(A_VAL, 16'h0000, "R7 one edge");
    @(negedge clk);
    rdChk(A_VAL, 16'h00FF, "R7 two edges");

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 4);
      case (op)
        0: begin wrReg(A_DIR, 16'($urandom)); padChk("R3 random dir"); end
        1: begin wrReg(A_VAL, 16'($urandom)); padChk("R4 random value"); end
        2: begin @(negedge clk); padIn = 8'($urandom); repeat (2) @(negedge clk); end
        3: begin @(negedge clk); rdChk(A_DIR, {8'h00, expDir}, "R5 random read"); end
        default: begin @(negedge clk);
          rdChk(A_VAL, expStatus(expDir, expVal, padIn), "R6 random status"); end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule